// File: doc/BRIEF.md
# Phase-Shifted Clock Output Divider

This block derives several programmable clock-enable waveforms from one base clock. It works synchronously on an oversampling clock that runs eight times faster than the base clock, so one oversample tick is a 45° step of the base period. A free-running 3-bit tick counter marks the eight phase positions. The block also drives a base-rate reference waveform that the lane outputs can be compared against.

Each lane has three settings: a coarse shift of 0 to 7 whole base cycles, a fine shift of 0 to 7 ticks, and a divide ratio. The coarse shift keeps the lane's divider parked after reset for the programmed number of base cycles. The fine shift then waits for the tick counter to reach the selected phase. The two shifts add together. Settings are captured only while reset is asserted. A mode input, when high at reset, makes lane 0 discard its shift settings, as needed for post-divider or external-feedback operation.

Each lane is a four-state machine with these states and transitions:
- LN_OFF: the lane is disabled. It leaves this state only through reset.
- LN_HOLD: the lane counts whole base cycles. It moves to LN_ALIGN at the last tick of the final held cycle.
- LN_ALIGN: the lane waits for its phase tick. It moves to LN_RUN on that tick.
- LN_RUN: the divider runs until the next reset.

On reset, an enabled lane loads LN_HOLD, or LN_ALIGN when its coarse shift is 0. A disabled lane loads LN_OFF.

Top module: `phase_div_top`

## Requirements
- R1: Cycle 0 is the first cycle after reset is released. `base_ref` is high in the cycles whose index k satisfies 1 ≤ (k mod 8) ≤ 4, and low in all other cycles.
- R2: A lane with fine shift f (3-bit field of `ph_sel`, lane i at bits 3i+2..3i) starts its waveform f cycles later than a lane with fine shift 0.
- R3: A coarse shift h (3-bit field of `hold_cyc`, lane i at bits 3i+2..3i) holds the divider idle for h base cycles, which delays the waveform by 8h cycles.
- R4: Fine and coarse shifts add. A lane's first high cycle is cycle 8h+f+1, including the extreme case h=7, f=7.
- R5: A divide ratio N ≥ 2 (4-bit field of `div_n`, lane i at bits 4i+3..4i) gives a period of 8N cycles with 8·floor(N/2) high cycles, starting high.
- R6: N=1 gives 4 high cycles out of every 8, which is `base_ref` delayed by the lane's shift. N=0 behaves as N=1.
- R7: If `fb_mode` is high at reset, lane 0 runs as if f=0 and h=0. Other lanes, and lane 0 when `fb_mode` is low, keep their shifts.
- R8: Settings and `fb_mode` are sampled only while `rst` is high. Changes made while running have no effect until the next reset.
- R9: `running[i]` rises in cycle 8h+f+1 and stays high until reset. `clk_en_o[i]` is low whenever `running[i]` is low.
- R10: A lane whose `lane_en` bit is low at reset keeps `clk_en_o` and `running` low.
- R11: While `rst` is high, after one clock edge, `base_ref`, every `clk_en_o` and every `running` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, eight ticks per base cycle |
| rst | input | 1 | Synchronous active-high reset; settings are captured while it is high |
| fb_mode | input | 1 | High selects post-divider/external-feedback mode, which suppresses lane 0 shifts |
| ph_sel | input | NUM_OUT*3 | Per-lane fine shift in ticks (45° steps) |
| hold_cyc | input | NUM_OUT*3 | Per-lane coarse shift in whole base cycles |
| div_n | input | NUM_OUT*DIV_W | Per-lane divide ratio; 0 is treated as 1 |
| lane_en | input | NUM_OUT | Per-lane enable |
| base_ref | output | 1 | Base-rate reference waveform |
| clk_en_o | output | NUM_OUT | Per-lane divided, phase-shifted waveform |
| running | output | NUM_OUT | Per-lane flag, high once the hold has expired and the divider runs |

## Verification
The checker tests on every cycle that the reference follows its fixed 8-cycle pattern. It also tests that a running flag, once high, stays high until reset, that a lane output is never high while its lane is not running, and that each waveform opens with a high stretch of at least two cycles. Start cycles for given shift values, exact periods and duty for each divide ratio, the lane 0 override, and the disregard of settings changed mid-run depend on the programmed values. Only the bench scenarios can show these, by comparing every lane against a cycle model over whole runs.

// File: rtl/pdv_pkg.sv
package pdv_pkg;
    localparam int TICK_W  = 3;
    localparam int N_STEPS = 1 << TICK_W;

    typedef enum logic [1:0] {
        LN_OFF   = 2'd0,
        LN_HOLD  = 2'd1,
        LN_ALIGN = 2'd2,
        LN_RUN   = 2'd3
    } lane_state_e;
endpackage

// File: rtl/pdv_tick_gen.sv
module pdv_tick_gen
    import pdv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [TICK_W-1:0] tick_o,
    output logic              ref_o
);
    logic [TICK_W-1:0] tick_q;
    logic              ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            ref_q  <= 1'b0;
        end else begin
            tick_q <= tick_q + 1'b1;
            ref_q  <= ~tick_q[TICK_W-1];
        end
    end

    assign tick_o = tick_q;
    assign ref_o  = ref_q;
endmodule

// File: rtl/pdv_lane.sv
module pdv_lane
    import pdv_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              force_i,
    input  logic              en_i,
    input  logic [TICK_W-1:0] ph_i,
    input  logic [2:0]        hold_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [TICK_W-1:0] tick_i,
    output logic              wave_o,
    output logic              run_o
);
    localparam int POS_W = DIV_W + TICK_W;
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(N_STEPS - 1);

    lane_state_e       state_q, state_d;
    logic [TICK_W-1:0] ph_q;
    logic [2:0]        cnt_q;
    logic [POS_W-1:0]  pos_q, last_q, hi_q;

    logic [DIV_W-1:0]  n_eff;
    logic [TICK_W-1:0] ph_eff;
    logic [2:0]        hold_eff;

    always_comb begin
        n_eff    = (div_i == '0) ? DIV_W'(1) : div_i;
        ph_eff   = force_i ? '0 : ph_i;
        hold_eff = force_i ? 3'd0 : hold_i;
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= ph_eff;
            cnt_q  <= hold_eff;
            pos_q  <= '0;
            last_q <= {n_eff, {TICK_W{1'b0}}} - POS_W'(1);
            hi_q   <= (n_eff == DIV_W'(1)) ? POS_W'(N_STEPS / 2)
                                           : {n_eff >> 1, {TICK_W{1'b0}}};
            if (!en_i)
                state_q <= LN_OFF;
            else if (hold_eff == 3'd0)
                state_q <= LN_ALIGN;
            else
                state_q <= LN_HOLD;
        end else begin
            state_q <= state_d;
            if (state_q == LN_HOLD && tick_i == LAST_TICK)
                cnt_q <= cnt_q - 3'd1;
            if (state_q == LN_ALIGN)
                pos_q <= '0;
            else if (state_q == LN_RUN)
                pos_q <= (pos_q == last_q) ? '0 : pos_q + POS_W'(1);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_OFF:   state_d = LN_OFF;
            LN_HOLD:  if (tick_i == LAST_TICK && cnt_q == 3'd1) state_d = LN_ALIGN;
            LN_ALIGN: if (tick_i == ph_q) state_d = LN_RUN;
            LN_RUN:   state_d = LN_RUN;
        endcase
    end

    // outputs
    always_comb begin
        run_o  = (state_q == LN_RUN);
        wave_o = (state_q == LN_RUN) && (pos_q < hi_q);
    end
endmodule

// File: rtl/phase_div_top.sv
module phase_div_top
    import pdv_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int DIV_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fb_mode,
    input  logic [NUM_OUT*3-1:0]     ph_sel,
    input  logic [NUM_OUT*3-1:0]     hold_cyc,
    input  logic [NUM_OUT*DIV_W-1:0] div_n,
    input  logic [NUM_OUT-1:0]       lane_en,
    output logic                     base_ref,
    output logic [NUM_OUT-1:0]       clk_en_o,
    output logic [NUM_OUT-1:0]       running
);
    logic [TICK_W-1:0] tick;

    pdv_tick_gen u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick),
        .ref_o  (base_ref)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        logic force_shift_off;
        if (i == 0) begin : g_first
            assign force_shift_off = fb_mode;
        end else begin : g_other
            assign force_shift_off = 1'b0;
        end

        pdv_lane #(.DIV_W(DIV_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .force_i (force_shift_off),
            .en_i    (lane_en[i]),
            .ph_i    (ph_sel[i*3 +: 3]),
            .hold_i  (hold_cyc[i*3 +: 3]),
            .div_i   (div_n[i*DIV_W +: DIV_W]),
            .tick_i  (tick),
            .wave_o  (clk_en_o[i]),
            .run_o   (running[i])
        );
    end
endmodule

// File: rtl/pdv_checker.sv
module pdv_checker #(
    parameter int NUM_OUT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               base_ref,
    input logic [NUM_OUT-1:0] clk_en_o,
    input logic [NUM_OUT-1:0] running
);
    logic [2:0] k_mod;

    always_ff @(posedge clk) begin
        if (rst) k_mod <= 3'd0;
        else     k_mod <= k_mod + 3'd1;
    end

    a_r1_ref_pattern: assert property (@(posedge clk) disable iff (rst)
        base_ref == (k_mod >= 3'd1 && k_mod <= 3'd4));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
        a_r9_run_sticky: assert property (@(posedge clk) disable iff (rst)
            running[i] |=> running[i]);

        a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
            !running[i] |-> !clk_en_o[i]);

        a_r5_start_high: assert property (@(posedge clk) disable iff (rst)
            $rose(running[i]) |-> clk_en_o[i]);

        a_r5_min_high: assert property (@(posedge clk) disable iff (rst)
            $rose(clk_en_o[i]) |=> clk_en_o[i]);
    end
endmodule

bind phase_div_top pdv_checker #(.NUM_OUT(NUM_OUT)) u_pdv_chk (
    .clk      (clk),
    .rst      (rst),
    .base_ref (base_ref),
    .clk_en_o (clk_en_o),
    .running  (running)
);

// File: tb/tb_phase_div_top.sv
`timescale 1ns/1ps
module tb_phase_div_top;
    localparam int NUM_OUT = 4;
    localparam int DIV_W   = 4;
    localparam int RUN_LEN = 200;

    typedef struct packed {
        logic [1:0] lane;
        logic [2:0] ph;
        logic [2:0] hold;
        logic [3:0] div;
        logic       en;
        logic       mode;
        logic       mid;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 3'd0, 4'd1,  1'b1, 1'b0, 1'b0},
        '{2'd1, 3'd3, 3'd0, 4'd1,  1'b1, 1'b0, 1'b0},
        '{2'd2, 3'd0, 3'd2, 4'd2,  1'b1, 1'b0, 1'b0},
        '{2'd3, 3'd5, 3'd3, 4'd3,  1'b1, 1'b0, 1'b0},
        '{2'd1, 3'd7, 3'd7, 4'd15, 1'b1, 1'b0, 1'b0},
        '{2'd0, 3'd4, 3'd2, 4'd4,  1'b1, 1'b1, 1'b0},
        '{2'd2, 3'd2, 3'd1, 4'd0,  1'b1, 1'b0, 1'b0},
        '{2'd3, 3'd1, 3'd1, 4'd2,  1'b0, 1'b0, 1'b0},
        '{2'd1, 3'd6, 3'd4, 4'd5,  1'b1, 1'b0, 1'b1},
        '{2'd0, 3'd4, 3'd2, 4'd4,  1'b1, 1'b0, 1'b0}
    };

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     fb_mode = 1'b0;
    logic [NUM_OUT*3-1:0]     ph_sel = '0;
    logic [NUM_OUT*3-1:0]     hold_cyc = '0;
    logic [NUM_OUT*DIV_W-1:0] div_n = '0;
    logic [NUM_OUT-1:0]       lane_en = '0;
    logic                     base_ref;
    logic [NUM_OUT-1:0]       clk_en_o;
    logic [NUM_OUT-1:0]       running;

    int n_checks = 0;
    int n_fail   = 0;

    int m_ph   [NUM_OUT];
    int m_hold [NUM_OUT];
    int m_div  [NUM_OUT];
    bit m_en   [NUM_OUT];

    always #2.5 clk = ~clk;

    phase_div_top #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .fb_mode(fb_mode), .ph_sel(ph_sel),
        .hold_cyc(hold_cyc), .div_n(div_n), .lane_en(lane_en),
        .base_ref(base_ref), .clk_en_o(clk_en_o), .running(running)
    );

    function automatic string tag_of(int v);
        case (v)
            0: return "R6";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R4";
            5: return "R7";
            6: return "R6";
            7: return "R10";
            8: return "R8";
            default: return "R7";
        endcase
    endfunction

    function automatic bit exp_run(int k, int ph, int hold, bit en);
        return en && (k >= 8 * hold + ph + 1);
    endfunction

    function automatic bit exp_wave(int k, int ph, int hold, int div, bit en);
        int n, start, p, hi;
        n = (div == 0) ? 1 : div;
        start = 8 * hold + ph;
        if (!en || k < start + 1) return 1'b0;
        p  = (k - start - 1) % (8 * n);
        hi = (n == 1) ? 4 : (n / 2) * 8;
        return p < hi;
    endfunction

    task automatic check(string req, bit ok, int act, int exp, string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_cfg(vec_t v);
        for (int i = 0; i < NUM_OUT; i++) begin
            m_ph[i] = i; m_hold[i] = i; m_div[i] = i + 1; m_en[i] = 1'b1;
        end
        m_ph[v.lane] = v.ph; m_hold[v.lane] = v.hold;
        m_div[v.lane] = v.div; m_en[v.lane] = v.en;
        for (int i = 0; i < NUM_OUT; i++) begin
            ph_sel[i*3 +: 3]           = 3'(m_ph[i]);
            hold_cyc[i*3 +: 3]         = 3'(m_hold[i]);
            div_n[i*DIV_W +: DIV_W]    = DIV_W'(m_div[i]);
            lane_en[i]                 = m_en[i];
        end
        fb_mode = v.mode;
        if (v.mode) begin
            m_ph[0] = 0; m_hold[0] = 0;
        end
    endtask

    task automatic run_vec(int idx, vec_t v);
        int wave_err, ref_err, run_err;
        int first_bad_act, first_bad_exp;
        wave_err = 0; ref_err = 0; run_err = 0;
        first_bad_act = 0; first_bad_exp = 0;
        @(negedge clk);
        rst = 1'b1;
        load_cfg(v);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < RUN_LEN; k++) begin
            #1;
            if (v.mid && k == 20) begin
                ph_sel = ~ph_sel; hold_cyc = '0; div_n = {NUM_OUT{4'd7}};
                lane_en = ~lane_en; fb_mode = ~fb_mode;
            end
            for (int i = 0; i < NUM_OUT; i++) begin
                bit ew, er;
                ew = exp_wave(k, m_ph[i], m_hold[i], m_div[i], m_en[i]);
                er = exp_run(k, m_ph[i], m_hold[i], m_en[i]);
                if (clk_en_o[i] !== ew) begin
                    if (wave_err == 0) begin
                        first_bad_act = int'(clk_en_o[i]); first_bad_exp = int'(ew);
                    end
                    wave_err++;
                end
                if (running[i] !== er) run_err++;
            end
            if (base_ref !== ((k % 8) >= 1 && (k % 8) <= 4)) ref_err++;
            @(negedge clk);
        end
        check(tag_of(idx), wave_err == 0, first_bad_act, first_bad_exp,
              $sformatf("vector %0d lane waveforms (%0d mismatches)", idx, wave_err));
        check("R1", ref_err == 0, ref_err, 0, $sformatf("vector %0d base_ref mismatches", idx));
        check("R9", run_err == 0, run_err, 0, $sformatf("vector %0d running mismatches", idx));
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R11: reset state at start
        repeat (3) @(negedge clk);
        check("R11", {base_ref, clk_en_o, running} == '0,
              int'({base_ref, clk_en_o, running}), 0, "outputs during initial reset");

        for (int v = 0; v < NV; v++) run_vec(v, VEC[v]);

        // R11: reset re-asserted mid-run clears everything after one edge
        @(negedge clk);
        rst = 1'b0;
        lane_en = '1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R11", {base_ref, clk_en_o, running} == '0,
              int'({base_ref, clk_en_o, running}), 0, "outputs after reset re-asserted");

        // R10: all lanes disabled, nothing ever runs
        lane_en = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 100; k++) begin
                #1;
                if (clk_en_o != '0 || running != '0) seen++;
                @(negedge clk);
            end
            check("R10", seen == 0, seen, 0, "disabled lanes active cycles");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule